// File: doc/BRIEF.md
# Four-Channel Sample Capture Sequencer

This block takes four simultaneous converter samples every sample clock, each already calibrated into a 16-bit lane holding a signed 14-bit value with fractional low bits. It joins them into one 64-bit word per clock and writes a programmed number of those words into a downstream write FIFO that feeds a bulk memory.

The host sets a word count and a source select, then pulses `start`. The sequencer latches both settings, spends one armed cycle, and then writes one word per clock for exactly the programmed number of cycles. After that it parks in a done state until `clear`, so the stored buffer can be read back.

A test source replaces the converter lanes with an incrementing 64-bit word index, so the stored image can be checked word by word. If the FIFO reports full during the capture, that word is dropped. A sticky flag records the drop, and the capture still ends on schedule.

Top module: `adc_capture_seq`

## Requirements
- R1: After reset, `busy`, `done`, `overflow` and `fifo_wr` are all 0.
- R2: A written word carries channel 1 in bits [15:0], channel 2 in [31:16], channel 3 in [47:32] and channel 4 in [63:48], taken from the lanes present in the cycle of the write.
- R3: A `start` seen in the idle state makes `busy` 1 in the next cycle. `fifo_wr` stays 0 in that armed cycle.
- R4: With a count N > 0, the capture covers exactly the N cycles after the armed cycle. In the following cycle, `done` is 1 and `busy` is 0, and `done` holds until `clear`.
- R5: With a count of 0, `done` rises in the cycle after the armed cycle and no word is ever written.
- R6: With the test source selected (`test_mode` = 1 at start), the word in capture cycle k (counting from 0) equals k as a 64-bit value.
- R7: When `fifo_full` is 1 in a capture cycle, `fifo_wr` is 0 in that cycle and `overflow` becomes 1 and stays 1 until the next start or clear. The dropped cycle still counts toward N.
- R8: Changes to `capture_len` or `test_mode` after the start cycle do not alter the length or the source of the capture that is running.
- R9: `clear` returns the block to idle from any state, with `busy`, `done` and `overflow` at 0 in the next cycle. A `start` outside idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a capture when idle |
| clear | input | 1 | Return to idle from any state |
| test_mode | input | 1 | 1 selects the word-index test source |
| capture_len | input | CNT_W | Number of words to capture |
| ch1_data | input | LANE_W | Channel 1 calibrated sample |
| ch2_data | input | LANE_W | Channel 2 calibrated sample |
| ch3_data | input | LANE_W | Channel 3 calibrated sample |
| ch4_data | input | LANE_W | Channel 4 calibrated sample |
| fifo_full | input | 1 | Downstream FIFO cannot accept a word |
| fifo_wr | output | 1 | Write strobe to the FIFO |
| fifo_data | output | 4*LANE_W | Packed word to the FIFO |
| busy | output | 1 | Armed or capturing |
| done | output | 1 | Capture finished |
| overflow | output | 1 | Sticky: a word was dropped on full |

## Verification
A wrong word counter or a bad length latch shows at the ports as a capture window that is too short or too long. The bench catches this at the first cycle where `fifo_wr` or `done` departs from the schedule computed from N. A corrupted test index shows in the first written word after the fault, and a lane swap shows in every written word. A lost or spurious overflow bit shows at the done check of the same run, and a stuck state shows one cycle after `clear`.

// File: rtl/adc_capture_seq.sv
`timescale 1ns/1ps
module adc_capture_seq #(
  parameter int LANE_W = 16,
  parameter int CNT_W  = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                clear,
  input  logic                test_mode,
  input  logic [CNT_W-1:0]    capture_len,
  input  logic [LANE_W-1:0]   ch1_data,
  input  logic [LANE_W-1:0]   ch2_data,
  input  logic [LANE_W-1:0]   ch3_data,
  input  logic [LANE_W-1:0]   ch4_data,
  input  logic                fifo_full,
  output logic                fifo_wr,
  output logic [4*LANE_W-1:0] fifo_data,
  output logic                busy,
  output logic                done,
  output logic                overflow
);
  localparam int WORD_W = 4 * LANE_W;

  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_CAPT, S_DONE} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt, len_q;
  logic             tmode_q;

  wire last_word = (cnt == len_q - CNT_W'(1));
  wire capturing = (st == S_CAPT);

  assign busy      = (st == S_ARMED) || capturing;
  assign done      = (st == S_DONE);
  assign fifo_wr   = capturing && !fifo_full;
  assign fifo_data = tmode_q ? WORD_W'(cnt) : {ch4_data, ch3_data, ch2_data, ch1_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      len_q    <= '0;
      tmode_q  <= 1'b0;
      overflow <= 1'b0;
    end else if (clear) begin
      st       <= S_IDLE;
      overflow <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st       <= S_ARMED;
          len_q    <= capture_len;
          tmode_q  <= test_mode;
          cnt      <= '0;
          overflow <= 1'b0;
        end
        S_ARMED: st <= (len_q == '0) ? S_DONE : S_CAPT;
        S_CAPT: begin
          cnt <= cnt + CNT_W'(1);
          if (fifo_full) overflow <= 1'b1;
          if (last_word) st <= S_DONE;
        end
        default: ;
      endcase
    end
  end

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) !rst_n |=> !busy && !done && !overflow); // R1
  AST_ARMED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start && !clear) |=> busy && !fifo_wr); // R3
  AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n) fifo_wr |-> busy); // R4
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (done && !clear) |=> done); // R4
  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ARMED && len_q == '0 && !clear) |=> done); // R5
  AST_NO_WRITE_FULL: assert property (@(posedge clk) disable iff (!rst_n) fifo_full |-> !fifo_wr); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clear && !(st == S_IDLE && start)) |=> overflow); // R7
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (capturing && !clear) |=> $stable(len_q) && $stable(tmode_q)); // R8
  AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !busy && !done && !overflow); // R9
endmodule

// File: tb/adc_capture_seq_tb_top.sv
`timescale 1ns/1ps
module adc_capture_seq_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0, start = 1'b0, clear = 1'b0, test_mode = 1'b0, fifo_full = 1'b0;
  logic [31:0] capture_len = '0;
  logic [15:0] ch1 = '0, ch2 = '0, ch3 = '0, ch4 = '0;
  logic        fifo_wr, busy, done, overflow;
  logic [63:0] fifo_data;
  int n_chk = 0, n_bad = 0;

  adc_capture_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .clear(clear), .test_mode(test_mode),
    .capture_len(capture_len), .ch1_data(ch1), .ch2_data(ch2), .ch3_data(ch3), .ch4_data(ch4),
    .fifo_full(fifo_full), .fifo_wr(fifo_wr), .fifo_data(fifo_data),
    .busy(busy), .done(done), .overflow(overflow));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_lanes(input int k, input int len);
    ch1 = 16'(k * 37 + 1 + len);
    ch2 = 16'(k * 91 + 16'h2000);
    ch3 = 16'(16'h8000 - k * 13);
    ch4 = 16'(k) ^ 16'h5A5A;
  endtask

  task automatic run_cap(input int len, input bit mode, input bit fen);
    bit any_full = 0;
    @(negedge clk);
    capture_len = 32'(len); test_mode = mode; start = 1'b1; fifo_full = 1'b0;
    @(negedge clk);
    start = 1'b0; capture_len = ~32'(len); test_mode = ~mode;
    #1;
    chk(busy == 1'b1, "R3 busy in armed cycle", 64'(busy), 64'd1);
    chk(fifo_wr == 1'b0, "R3 no write in armed cycle", 64'(fifo_wr), 64'd0);
    for (int k = 0; k < len; k++) begin
      bit full;
      @(negedge clk);
      full = fen && (k % 3 == 1);
      fifo_full = full; start = (k == 1); set_lanes(k, len);
      #1;
      chk(fifo_wr == !full, "R4/R7 write strobe in capture window", 64'(fifo_wr), 64'(!full));
      if (!full) begin
        if (mode) chk(fifo_data == 64'(k), "R6 test word index", fifo_data, 64'(k));
        else chk(fifo_data == {ch4, ch3, ch2, ch1}, "R2 lane packing", fifo_data, {ch4, ch3, ch2, ch1});
      end
      any_full |= full;
    end
    @(negedge clk);
    fifo_full = 1'b0; start = 1'b0;
    #1;
    chk(done == 1'b1, (len == 0) ? "R5 zero count done" : "R4 done after N", 64'(done), 64'd1);
    chk(busy == 1'b0, "R4 busy low when done", 64'(busy), 64'd0);
    chk(fifo_wr == 1'b0, "R5/R8 no write past N", 64'(fifo_wr), 64'd0);
    chk(overflow == any_full, "R7 overflow flag", 64'(overflow), 64'(any_full));
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1;
    chk(done == 1'b1 && busy == 1'b0, "R9 start ignored in done", 64'(done), 64'd1);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    #1;
    chk(!done && !busy && !overflow, "R9 clear to idle", {61'd0, done, busy, overflow}, 64'd0);
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !done && !overflow && !fifo_wr, "R1 reset state",
        {60'd0, busy, done, overflow, fifo_wr}, 64'd0);
    rst_n = 1'b1;
    for (int len = 0; len <= 7; len++)
      for (int m = 0; m < 2; m++)
        for (int f = 0; f < 2; f++)
          run_cap(len, m[0], f[0]);
    run_cap(200, 1'b1, 1'b1);
    run_cap(150, 1'b0, 1'b0);
    @(negedge clk);
    capture_len = 32'd10; test_mode = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    #1;
    chk(!busy && !fifo_wr && !done, "R9 clear aborts capture", {61'd0, busy, fifo_wr, done}, 64'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule